// File: doc/BRIEF.md
# Vertical Frame Sequencer with Double-Buffered Panel Bases

The block steps an LCD panel through its four vertical phases, one line at a time, driven by a line tick from the horizontal timing generator. The phase order is sync, back porch, active video, front porch, and the order repeats. Each phase length is a programmable number of lines.

Software writes the upper and lower panel frame base addresses into pending registers. The block moves them into the live registers, which feed the DMA master, only at the start of vertical sync. This lets software prepare the next buffer while the current frame is being read out. Two sticky interrupt sources are provided: a base-update event, and a compare event tied to the entry of a chosen phase.

The block also raises a refill request when either pixel FIFO has enough free entries, using a selectable threshold. A power enable gates the 24-bit pixel output.

Top module: `lcd_frame_seq`

## Requirements
- R1: After reset, the control, mask, status and base registers read 0. The phase is sync (0), and `irq_o`, `dma_req_o` and `pix_o` are 0.
- R2: While enabled, each line tick advances a per-phase line counter. A phase lasts as many lines as its length input, and a length of 0 counts as 1. The phase codes run sync 0, back porch 1, active 2, front porch 3, then return to 0.
- R3: Writes to address 1 (upper) or 2 (lower) set only the pending base, with bits [2:0] stored as 0. The live bases (`upper_base_o`, `lower_base_o`, and reads of addresses 5 and 6) change only when sync is entered.
- R4: Each entry into sync sets status bit 0 (base update). Turning the enable bit from 0 to 1 counts as an entry into sync.
- R5: Control bits [3:2] select a phase code. Each entry into that phase sets status bit 1 (compare), once per frame.
- R6: Status bits (address 4) are sticky. Writing 1 to a bit of address 4 clears that bit, and writing 0 leaves it unchanged.
- R7: `irq_o` is the OR over status bits ANDed with the mask bits at address 3 (bit 0 base update, bit 1 compare).
- R8: `dma_req_o` is 1 when the sequencer is enabled and either FIFO's free count is at least the threshold. The threshold is 4 when control bit 4 is 0 and 8 when it is 1. `dma_req_o` is 0 while disabled.
- R9: `pix_o` equals `pix_i` when control bit 1 (power) is 1, and is all zero when it is 0.
- R10: Clearing control bit 0 (enable) returns the phase to sync with its counter reset and causes no phase-entry event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from `addr_i` |
| line_tick_i | input | 1 | One-cycle pulse per line |
| vsync_len_i | input | 10 | Sync length in lines |
| vbp_len_i | input | 10 | Back porch length in lines |
| vact_len_i | input | 10 | Active length in lines |
| vfp_len_i | input | 10 | Front porch length in lines |
| fifo_upper_free_i | input | 5 | Free entries in upper FIFO |
| fifo_lower_free_i | input | 5 | Free entries in lower FIFO |
| pix_i | input | 24 | Pixel data in |
| pix_o | output | 24 | Gated pixel data |
| upper_base_o | output | 32 | Live upper base |
| lower_base_o | output | 32 | Live lower base |
| vphase_o | output | 2 | Current phase code |
| dma_req_o | output | 1 | FIFO refill request |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench writes new base addresses in the middle of a frame. A design that commits them on the write itself, or at some phase other than sync, shows live bases that move too early. Phase lengths of 0 and 1 are included: a counter that treats 0 as a full wrap would stall the sequence for many lines. The bench clears the compare status after it fires and checks that it stays clear for the rest of the frame, which exposes level-sensitive setting. The free counts are driven at 3, 4, 7 and 8 under both thresholds, so an off-by-one comparison or a swapped threshold asserts the request at the wrong count.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_BP   = 2'd1,
    PH_ACT  = 2'd2,
    PH_FP   = 2'd3
  } vphase_e;

  localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] A_UPND = 3'd1;
  localparam logic [REG_AW-1:0] A_LPND = 3'd2;
  localparam logic [REG_AW-1:0] A_MASK = 3'd3;
  localparam logic [REG_AW-1:0] A_STAT = 3'd4;
  localparam logic [REG_AW-1:0] A_UCUR = 3'd5;
  localparam logic [REG_AW-1:0] A_LCUR = 3'd6;

  localparam int NIRQ = 2;
  localparam int IRQ_BU  = 0;
  localparam int IRQ_CMP = 1;
endpackage

// File: rtl/lcd_vphase_gen.sv
module lcd_vphase_gen
  import lcd_seq_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   line_tick_i,
  input  logic [3:0][LINE_W-1:0] len_i,
  output vphase_e                phase_o,
  output logic [3:0]             start_o
);
  localparam int CW = LINE_W + 1;

  vphase_e           ph_q, ph_prev_q;
  logic [LINE_W-1:0] cnt_q;
  logic              en_d_q;
  logic [CW-1:0]     eff_len;
  logic              last_line;
  logic              entry;

  always_comb begin
    eff_len = {1'b0, len_i[ph_q]};
    if (len_i[ph_q] == '0) eff_len = CW'(1);
    last_line = (({1'b0, cnt_q} + CW'(1)) >= eff_len);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_SYNC;
      ph_prev_q <= PH_SYNC;
      cnt_q     <= '0;
      en_d_q    <= 1'b0;
    end else begin
      en_d_q    <= en_i;
      ph_prev_q <= ph_q;
      if (!en_i) begin
        ph_q  <= PH_SYNC;
        cnt_q <= '0;
      end else if (line_tick_i) begin
        if (last_line) begin
          ph_q  <= vphase_e'(ph_q + 2'd1);
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + LINE_W'(1);
        end
      end
    end
  end

  // phase entry: either a phase change or the enable edge (entering sync)
  assign entry   = en_i && (!en_d_q || (ph_q != ph_prev_q));
  assign start_o = entry ? (4'b0001 << ph_q) : 4'b0000;
  assign phase_o = ph_q;
endmodule

// File: rtl/lcd_base_shadow.sv
module lcd_base_shadow #(
  parameter int DW     = 32,
  parameter int NPANEL = 2,
  parameter int ALIGN  = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NPANEL-1:0]           wr_i,
  input  logic [DW-1:0]               wdata_i,
  input  logic                        commit_i,
  output logic [NPANEL-1:0][DW-1:0]   pend_o,
  output logic [NPANEL-1:0][DW-1:0]   cur_o
);
  logic unused_low;
  assign unused_low = ^wdata_i[ALIGN-1:0];

  for (genvar p = 0; p < NPANEL; p++) begin : g_panel
    logic [DW-ALIGN-1:0] pend_q, cur_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= '0;
        cur_q  <= '0;
      end else begin
        if (wr_i[p]) pend_q <= wdata_i[DW-1:ALIGN];
        if (commit_i) cur_q <= pend_q;
      end
    end

    assign pend_o[p] = {pend_q, {ALIGN{1'b0}}};
    assign cur_o[p]  = {cur_q, {ALIGN{1'b0}}};
  end
endmodule

// File: rtl/lcd_irq_ctrl.sv
module lcd_irq_ctrl #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | set_i;  // set wins
  end

  assign status_o = stat_q;
  assign irq_o    = |(stat_q & mask_i);
endmodule

// File: rtl/lcd_dma_req.sv
module lcd_dma_req #(
  parameter int CNT_W   = 5,
  parameter int NFIFO   = 2,
  parameter int THR_LO  = 4,
  parameter int THR_HI  = 8
) (
  input  logic                       en_i,
  input  logic                       wm_hi_i,
  input  logic [NFIFO-1:0][CNT_W-1:0] free_i,
  output logic                       req_o
);
  logic [CNT_W-1:0] thr;
  logic [NFIFO-1:0] hit;

  assign thr = wm_hi_i ? CNT_W'(THR_HI) : CNT_W'(THR_LO);

  for (genvar f = 0; f < NFIFO; f++) begin : g_fifo
    assign hit[f] = (free_i[f] >= thr);
  end

  assign req_o = en_i && (|hit);
endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
  import lcd_seq_pkg::*;
#(
  parameter int DW     = 32,
  parameter int LINE_W = 10,
  parameter int CNT_W  = 5,
  parameter int PIX_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              line_tick_i,
  input  logic [LINE_W-1:0] vsync_len_i,
  input  logic [LINE_W-1:0] vbp_len_i,
  input  logic [LINE_W-1:0] vact_len_i,
  input  logic [LINE_W-1:0] vfp_len_i,
  input  logic [CNT_W-1:0]  fifo_upper_free_i,
  input  logic [CNT_W-1:0]  fifo_lower_free_i,
  input  logic [PIX_W-1:0]  pix_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic [DW-1:0]     upper_base_o,
  output logic [DW-1:0]     lower_base_o,
  output logic [1:0]        vphase_o,
  output logic              dma_req_o,
  output logic              irq_o
);
  localparam int NPANEL = 2;
  localparam int CTRL_W = 5;

  logic              en_q, pwr_q, wm_q;
  logic [1:0]        cmp_sel_q;
  logic [NIRQ-1:0]   mask_q;
  logic [NIRQ-1:0]   irq_status, irq_set, stat_clr;
  logic [3:0]        ph_start;
  vphase_e           phase;
  logic [NPANEL-1:0] base_wr;
  logic [NPANEL-1:0][DW-1:0] pend, cur;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      pwr_q     <= 1'b0;
      cmp_sel_q <= 2'b00;
      wm_q      <= 1'b0;
      mask_q    <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_CTRL) begin
        en_q      <= wdata_i[0];
        pwr_q     <= wdata_i[1];
        cmp_sel_q <= wdata_i[3:2];
        wm_q      <= wdata_i[4];
      end
      if (addr_i == A_MASK) mask_q <= wdata_i[NIRQ-1:0];
    end
  end

  lcd_vphase_gen #(.LINE_W(LINE_W)) i_vphase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_q),
    .line_tick_i(line_tick_i),
    .len_i      ({vfp_len_i, vact_len_i, vbp_len_i, vsync_len_i}),
    .phase_o    (phase),
    .start_o    (ph_start)
  );

  assign base_wr[0] = wr_en_i && (addr_i == A_UPND);
  assign base_wr[1] = wr_en_i && (addr_i == A_LPND);

  lcd_base_shadow #(.DW(DW), .NPANEL(NPANEL)) i_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (base_wr),
    .wdata_i (wdata_i),
    .commit_i(ph_start[PH_SYNC]),
    .pend_o  (pend),
    .cur_o   (cur)
  );

  assign irq_set[IRQ_BU]  = ph_start[PH_SYNC];
  assign irq_set[IRQ_CMP] = ph_start[cmp_sel_q];
  assign stat_clr = (wr_en_i && addr_i == A_STAT) ? wdata_i[NIRQ-1:0] : '0;

  lcd_irq_ctrl #(.N(NIRQ)) i_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (irq_set),
    .clr_i   (stat_clr),
    .mask_i  (mask_q),
    .status_o(irq_status),
    .irq_o   (irq_o)
  );

  lcd_dma_req #(.CNT_W(CNT_W), .NFIFO(2)) i_dma (
    .en_i   (en_q),
    .wm_hi_i(wm_q),
    .free_i ({fifo_lower_free_i, fifo_upper_free_i}),
    .req_o  (dma_req_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o = DW'({wm_q, cmp_sel_q, pwr_q, en_q});
      A_UPND: rdata_o = pend[0];
      A_LPND: rdata_o = pend[1];
      A_MASK: rdata_o = DW'(mask_q);
      A_STAT: rdata_o = DW'(irq_status);
      A_UCUR: rdata_o = cur[0];
      A_LCUR: rdata_o = cur[1];
      default: rdata_o = '0;
    endcase
  end

  assign upper_base_o = cur[0];
  assign lower_base_o = cur[1];
  assign vphase_o     = phase;
  assign pix_o        = pwr_q ? pix_i : '0;
endmodule

// File: rtl/lcd_frame_seq_chk.sv
module lcd_frame_seq_chk #(
  parameter int DW    = 32,
  parameter int PIX_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             pwr_i,
  input logic [3:0]       start_i,
  input logic [1:0]       status_i,
  input logic [1:0]       clr_i,
  input logic [DW-1:0]    upper_base_i,
  input logic             dma_req_i,
  input logic [PIX_W-1:0] pix_i,
  input logic [1:0]       phase_i
);
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && (phase_i != $past(phase_i))) |-> (phase_i == 2'($past(phase_i) + 2'd1))); // R2
  AST_BASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i[0] |=> $stable(upper_base_i)); // R3
  AST_BU_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i[0] |=> status_i[0]); // R4
  AST_ONE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_i)); // R5
  AST_STICKY_BU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[0] && !clr_i[0]) |=> status_i[0]); // R6
  AST_STICKY_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[1] && !clr_i[1]) |=> status_i[1]); // R6
  AST_DMA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !dma_req_i); // R8
  AST_PIX_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_i |-> (pix_i == '0)); // R9
  AST_NO_ENTRY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (start_i == 4'b0000)); // R10
endmodule

bind lcd_frame_seq lcd_frame_seq_chk #(.DW(DW), .PIX_W(PIX_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_q),
  .pwr_i       (pwr_q),
  .start_i     (ph_start),
  .status_i    (irq_status),
  .clr_i       (stat_clr),
  .upper_base_i(upper_base_o),
  .dma_req_i   (dma_req_o),
  .pix_i       (pix_o),
  .phase_i     (vphase_o)
);

// File: tb/test_lcd_frame_seq.sv
module test_lcd_frame_seq;
  localparam int DW = 32, LW = 10, CW = 5, PW = 24;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [2:0]    addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          line_tick_i = 1'b0;
  logic [LW-1:0] len [4];
  logic [CW-1:0] fu = '0, fl = '0;
  logic [PW-1:0] pix_i = '0, pix_o;
  logic [DW-1:0] ub_o, lb_o;
  logic [1:0]    vphase_o;
  logic          dma_req_o, irq_o;

  int checks = 0, errors = 0;

  // bench model state
  int          m_ph, m_cnt, m_sel;
  logic [1:0]  m_stat, m_mask;
  logic [DW-1:0] m_pu, m_pl, m_cu, m_cl;
  logic        m_en, m_wm;

  always #10 clk = ~clk;

  lcd_frame_seq i_lcd_frame_seq (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .line_tick_i(line_tick_i),
    .vsync_len_i(len[0]), .vbp_len_i(len[1]), .vact_len_i(len[2]), .vfp_len_i(len[3]),
    .fifo_upper_free_i(fu), .fifo_lower_free_i(fl), .pix_i(pix_i), .pix_o(pix_o),
    .upper_base_o(ub_o), .lower_base_o(lb_o), .vphase_o(vphase_o),
    .dma_req_o(dma_req_o), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [DW-1:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic m_enter(int ph);
    if (ph == 0) begin m_stat[0] = 1'b1; m_cu = m_pu; m_cl = m_pl; end
    if (ph == m_sel) m_stat[1] = 1'b1;
  endtask

  function automatic int eff(logic [LW-1:0] l);
    return (l == 0) ? 1 : int'(l);
  endfunction

  task automatic set_ctrl(logic en, logic pwr, int sel, logic wm);
    wr(3'd0, DW'({wm, sel[1:0], pwr, en}));
    if (en && !m_en) begin m_ph = 0; m_cnt = 0; m_sel = sel; m_enter(0); end
    if (!en) begin m_ph = 0; m_cnt = 0; end
    m_sel = sel; m_en = en; m_wm = wm;
    idle(2);
  endtask

  task automatic tick;
    @(negedge clk); line_tick_i = 1'b1;
    @(negedge clk); line_tick_i = 1'b0;
    if (m_en) begin
      if (m_cnt + 1 >= eff(len[m_ph])) begin
        m_ph = (m_ph + 1) % 4; m_cnt = 0; m_enter(m_ph);
      end else m_cnt++;
    end
    idle(2);
  endtask

  function automatic logic exp_dma(logic [CW-1:0] a, logic [CW-1:0] b);
    int t = m_wm ? 8 : 4;
    return m_en && (int'(a) >= t || int'(b) >= t);
  endfunction

  task automatic chk_dma(logic [CW-1:0] a, logic [CW-1:0] b);
    fu = a; fl = b; #1;
    chk("R8 dma_req", DW'(dma_req_o), DW'(exp_dma(a, b)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    void'($urandom(1234));
    for (int i = 0; i < 4; i++) len[i] = LW'(2);
    m_ph = 0; m_cnt = 0; m_sel = 0; m_stat = 0; m_mask = 0;
    m_pu = 0; m_pl = 0; m_cu = 0; m_cl = 0; m_en = 0; m_wm = 0;
    pix_i = 24'hA5C3F1; fu = 5'd10; fl = 5'd10;
    idle(3); rst_ni = 1'b1; idle(1);

    // R1 reset state
    rd(3'd0, r); chk("R1 ctrl", r, 0);
    rd(3'd3, r); chk("R1 mask", r, 0);
    rd(3'd4, r); chk("R1 status", r, 0);
    rd(3'd5, r); chk("R1 upper base", r, 0);
    rd(3'd2, r); chk("R1 lower pending", r, 0);
    chk("R1 phase", DW'(vphase_o), 0);
    chk("R1 irq", DW'(irq_o), 0);
    chk("R1 dma", DW'(dma_req_o), 0);
    chk("R1 pix", DW'(pix_o), 0);

    // R9 power gating
    set_ctrl(1'b0, 1'b1, 0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      pix_i = PW'($urandom); #1;
      chk("R9 pix pass", DW'(pix_o), DW'(pix_i));
    end
    set_ctrl(1'b0, 1'b0, 0, 1'b0);
    pix_i = 24'hFFFFFF; #1;
    chk("R9 pix gated", DW'(pix_o), 0);

    // R8 disabled holds request low
    chk_dma(5'd31, 5'd31);

    // R3 pending only before enable, alignment
    wr(3'd1, 32'h1234_567F); m_pu = 32'h1234_5678;
    wr(3'd2, 32'hFFFF_FFFF); m_pl = 32'hFFFF_FFF8;
    rd(3'd1, r); chk("R3 upper pending aligned", r, m_pu);
    rd(3'd2, r); chk("R3 lower pending aligned", r, m_pl);
    chk("R3 live upper unchanged", ub_o, 0);
    chk("R3 live lower unchanged", lb_o, 0);

    // R4 enable counts as sync entry
    set_ctrl(1'b1, 1'b1, 2, 1'b0);
    chk("R4 commit upper", ub_o, m_cu);
    rd(3'd6, r); chk("R4 commit lower", r, m_cl);
    rd(3'd4, r); chk("R4 status", r, DW'(m_stat));

    // R8 directed thresholds
    chk_dma(5'd3, 5'd0); chk_dma(5'd0, 5'd4); chk_dma(5'd3, 5'd3);
    set_ctrl(1'b1, 1'b1, 2, 1'b1);
    chk_dma(5'd7, 5'd7); chk_dma(5'd8, 5'd0); chk_dma(5'd4, 5'd8);
    set_ctrl(1'b0, 1'b1, 2, 1'b0);
    m_stat = 0; wr(3'd4, 32'h3);

    // random rounds: R2, R3, R4, R5, R6, R7, R10
    for (int rnd = 0; rnd < 8; rnd++) begin
      for (int i = 0; i < 4; i++) len[i] = LW'($urandom_range(0, 4));
      if (rnd == 0) begin len[0] = 0; len[1] = 1; len[2] = 3; len[3] = 0; end
      set_ctrl(1'b1, 1'b1, int'($urandom_range(0, 3)), 1'($urandom));
      for (int t = 0; t < 30; t++) begin
        tick();
        chk("R2 phase", DW'(vphase_o), DW'(m_ph));
        rd(3'd4, r); chk("R4/R5 status", r, DW'(m_stat));
        chk("R3 live upper", ub_o, m_cu);
        chk("R3 live lower", lb_o, m_cl);
        chk("R7 irq", DW'(irq_o), DW'(|(m_stat & m_mask)));
        chk_dma(CW'($urandom_range(0, 12)), CW'($urandom_range(0, 12)));
        case ($urandom_range(0, 3))
          0: begin
            logic [1:0] c = 2'($urandom);
            wr(3'd4, DW'(c)); m_stat = m_stat & ~c;
            rd(3'd4, r); chk("R6 w1c", r, DW'(m_stat));
          end
          1: begin
            m_mask = 2'($urandom); wr(3'd3, DW'(m_mask));
            chk("R7 irq mask", DW'(irq_o), DW'(|(m_stat & m_mask)));
          end
          2: begin
            logic [DW-1:0] d = DW'($urandom);
            if ($urandom_range(0, 1) == 0) begin wr(3'd1, d); m_pu = {d[DW-1:3], 3'b000}; end
            else begin wr(3'd2, d); m_pl = {d[DW-1:3], 3'b000}; end
            chk("R3 mid-frame write held", ub_o, m_cu);
          end
          default: ;
        endcase
      end
      // R10 disable
      wr(3'd4, 32'h3); m_stat = 0;
      set_ctrl(1'b0, 1'b1, m_sel, m_wm);
      chk("R10 phase to sync", DW'(vphase_o), 0);
      rd(3'd4, r); chk("R10 no event", r, 0);
      tick();
      chk("R10 ticks ignored", DW'(vphase_o), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule